// File: doc/BRIEF.md
# Double-Press Lamp Brightness Controller

This block drives a lamp with three levels: dark, normal and bright. A single-cycle press pulse steps the lamp between levels. How far it steps depends on how long ago the previous press came. A separate tick-enable input supplies the time base. The block counts ticks after the lamp is switched on, and that count decides what the next press does. A quick second press makes the lamp brighter. A slow second press switches it off.

The block is fully synchronous to one clock and has a synchronous, active-high reset. It reports the current level in two forms: a three-bit one-hot vector and a two-bit code. The quick-press window is set by the parameter `QUICK_TICKS`, counted in ticks. Its default is 3.

Top module: `lamp_dblpress_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the lamp goes dark after that edge (`lvl_code` = 0, `lvl_onehot` = 3'b001). Reset takes priority over a press in the same cycle.
- R2: A press while dark sets the lamp to normal (`lvl_code` = 1) after the edge. It also restarts the interval count from zero.
- R3: A press while normal, with the interval count at or below `QUICK_TICKS`, sets the lamp to bright (`lvl_code` = 2). This includes a count of zero.
- R4: A press while normal, with the interval count above `QUICK_TICKS`, sets the lamp dark.
- R5: A press while bright sets the lamp dark.
- R6: In a cycle without a press, the level does not change, whether or not a tick arrives.
- R7: The interval count advances by one per cycle with `tick` high. It stops at `QUICK_TICKS`+1 and never wraps, so any long wait still counts as a late press.
- R8: When press and tick arrive in the same cycle, the press is judged on the count before that tick. A press while dark clears the count even if a tick arrives in the same cycle.
- R9: `lvl_onehot` always has exactly one bit set, and that bit is bit `lvl_code`. The codes are 0 = dark, 1 = normal and 2 = bright.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| press | input | 1 | One-cycle button press pulse |
| tick | input | 1 | Time-base enable, one count per high cycle |
| lvl_onehot | output | 3 | One-hot level: bit0 dark, bit1 normal, bit2 bright |
| lvl_code | output | 2 | Encoded level: 0 dark, 1 normal, 2 bright |

## Verification
The level is a single register stage. A press or reset sampled at one edge is therefore visible on both outputs immediately after that same edge, with no further latency. The bench drives each stimulus at the falling edge and checks both outputs one nanosecond after the next rising edge. The interval count has no port, so its value is observed one press later. The saturation case, the same-cycle press-and-tick case and the cleared count are each judged by whether the following press produces bright or dark.

// File: rtl/lamp_pkg.sv
package lamp_pkg;

    typedef enum logic [1:0] {
        LAMP_DARK   = 2'd0,
        LAMP_NORM   = 2'd1,
        LAMP_BRIGHT = 2'd2
    } lamp_mode_e;

    typedef struct packed {
        lamp_mode_e mode;
    } mode_regs_t;

    localparam int LEVELS = 3;

endpackage

// File: rtl/gap_counter.sv
module gap_counter #(
    parameter int QUICK_TICKS = 3,
    parameter int CNT_W       = $clog2(QUICK_TICKS + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] gap_cnt
);
    localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(QUICK_TICKS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && (cnt_q < SAT_VAL)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign gap_cnt = cnt_q;

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= SAT_VAL); // R7
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr && tick && cnt_q < SAT_VAL) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7

endmodule

// File: rtl/lamp_mode_fsm.sv
module lamp_mode_fsm
    import lamp_pkg::*;
#(
    parameter int QUICK_TICKS = 3,
    parameter int CNT_W       = $clog2(QUICK_TICKS + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             press,
    input  logic [CNT_W-1:0] gap_cnt,
    output lamp_mode_e       mode,
    output logic             gap_clr
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUICK_TICKS);

    mode_regs_t regs_d, regs_q;
    logic       quick;

    assign quick = (gap_cnt <= LIMIT);

    always_comb begin
        regs_d  = regs_q;
        gap_clr = 1'b0;
        if (press) begin
            unique case (regs_q.mode)
                LAMP_DARK: begin
                    regs_d.mode = LAMP_NORM;
                    gap_clr     = 1'b1;
                end
                LAMP_NORM:   regs_d.mode = quick ? LAMP_BRIGHT : LAMP_DARK;
                LAMP_BRIGHT: regs_d.mode = LAMP_DARK;
                default:     regs_d.mode = LAMP_DARK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q.mode <= LAMP_DARK;
        else     regs_q      <= regs_d;
    end

    assign mode = regs_q.mode;

    AST_QUICK_BRIGHT: assert property (@(posedge clk) disable iff (rst)
        (press && regs_q.mode == LAMP_NORM && gap_cnt <= LIMIT) |=> (regs_q.mode == LAMP_BRIGHT)); // R3
    AST_LATE_DARK: assert property (@(posedge clk) disable iff (rst)
        (press && regs_q.mode == LAMP_NORM && gap_cnt > LIMIT) |=> (regs_q.mode == LAMP_DARK)); // R4
    AST_BRIGHT_EXIT: assert property (@(posedge clk) disable iff (rst)
        (press && regs_q.mode == LAMP_BRIGHT) |=> (regs_q.mode == LAMP_DARK)); // R5
    AST_DARK_ON: assert property (@(posedge clk) disable iff (rst)
        (press && regs_q.mode == LAMP_DARK) |=> (regs_q.mode == LAMP_NORM)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !press |=> $stable(regs_q.mode)); // R6

endmodule

// File: rtl/lamp_level_enc.sv
module lamp_level_enc
    import lamp_pkg::*;
(
    input  lamp_mode_e        mode,
    output logic [LEVELS-1:0] onehot,
    output logic [1:0]        code
);
    always_comb begin
        code   = mode;
        onehot = '0;
        unique case (mode)
            LAMP_NORM:   onehot[1] = 1'b1;
            LAMP_BRIGHT: onehot[2] = 1'b1;
            default:     onehot[0] = 1'b1;
        endcase
    end
endmodule

// File: rtl/lamp_dblpress_ctrl.sv
module lamp_dblpress_ctrl
    import lamp_pkg::*;
#(
    parameter int QUICK_TICKS = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        press,
    input  logic        tick,
    output logic [2:0]  lvl_onehot,
    output logic [1:0]  lvl_code
);
    localparam int CNT_W = $clog2(QUICK_TICKS + 2);

    logic [CNT_W-1:0] gap_cnt;
    logic             gap_clr;
    lamp_mode_e       mode;

    gap_counter #(.QUICK_TICKS(QUICK_TICKS), .CNT_W(CNT_W)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .clr     (gap_clr),
        .tick    (tick),
        .gap_cnt (gap_cnt)
    );

    lamp_mode_fsm #(.QUICK_TICKS(QUICK_TICKS), .CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .press   (press),
        .gap_cnt (gap_cnt),
        .mode    (mode),
        .gap_clr (gap_clr)
    );

    lamp_level_enc u_enc (
        .mode   (mode),
        .onehot (lvl_onehot),
        .code   (lvl_code)
    );

    AST_LEVEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(lvl_onehot) == 1); // R9
    AST_LEVEL_AGREE: assert property (@(posedge clk) disable iff (rst)
        lvl_onehot[lvl_code] == 1'b1); // R9
    AST_RESET_DARK: assert property (@(posedge clk)
        rst |=> (lvl_code == 2'd0)); // R1

endmodule

// File: tb/tb_lamp_dblpress_ctrl.sv
module tb_lamp_dblpress_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       press = 1'b0;
    logic       tick = 1'b0;
    logic [2:0] lvl_onehot;
    logic [1:0] lvl_code;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    lamp_dblpress_ctrl #(.QUICK_TICKS(3)) dut (
        .clk        (clk),
        .rst        (rst),
        .press      (press),
        .tick       (tick),
        .lvl_onehot (lvl_onehot),
        .lvl_code   (lvl_code)
    );

    // entry: {req[3:0], press, tick, expected code[1:0]}
    localparam int NVEC = 21;
    localparam logic [7:0] VEC [NVEC] = '{
        {4'd6, 1'b0, 1'b1, 2'd0},  // R6 tick while dark
        {4'd2, 1'b1, 1'b0, 2'd1},  // R2 switch on
        {4'd6, 1'b0, 1'b1, 2'd1},  // count 1
        {4'd6, 1'b0, 1'b1, 2'd1},  // count 2
        {4'd3, 1'b1, 1'b0, 2'd2},  // R3 quick press at 2
        {4'd6, 1'b0, 1'b1, 2'd2},  // R6 hold bright
        {4'd5, 1'b1, 1'b0, 2'd0},  // R5 bright to dark
        {4'd2, 1'b1, 1'b0, 2'd1},
        {4'd6, 1'b0, 1'b1, 2'd1},
        {4'd6, 1'b0, 1'b1, 2'd1},
        {4'd6, 1'b0, 1'b1, 2'd1},  // count 3
        {4'd8, 1'b1, 1'b1, 2'd2},  // R8 press+tick judged at 3
        {4'd5, 1'b1, 1'b0, 2'd0},
        {4'd2, 1'b1, 1'b0, 2'd1},
        {4'd6, 1'b0, 1'b1, 2'd1},
        {4'd6, 1'b0, 1'b1, 2'd1},
        {4'd6, 1'b0, 1'b1, 2'd1},
        {4'd6, 1'b0, 1'b1, 2'd1},  // count 4
        {4'd4, 1'b1, 1'b0, 2'd0},  // R4 late press
        {4'd2, 1'b1, 1'b0, 2'd1},
        {4'd3, 1'b1, 1'b0, 2'd2}   // R3 boundary at zero
    };

    task automatic check(input logic [1:0] exp, input string req);
        logic [2:0] exp_oh;
        exp_oh = 3'b001 << exp;
        n_run++;
        if (lvl_code !== exp || lvl_onehot !== exp_oh) begin
            n_fail++;
            $display("FAIL %s: code=%0d onehot=%b expected code=%0d onehot=%b",
                     req, lvl_code, lvl_onehot, exp, exp_oh);
        end
    endtask

    task automatic step(input logic p, input logic t);
        @(negedge clk);
        press = p;
        tick  = t;
        @(posedge clk);
        #1;
        press = 1'b0;
        tick  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(2'd0, "R1 reset state");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            step(VEC[i][3], VEC[i][2]);
            tag = $sformatf("R%0d table step %0d", VEC[i][7:4], i);
            check(VEC[i][1:0], tag);
        end

        // R7: long wait saturates, no wrap to a small value
        do_reset();
        step(1'b1, 1'b0);
        check(2'd1, "R7 on");
        for (int k = 0; k < 16; k++) step(1'b0, 1'b1);
        check(2'd1, "R7 hold during ticks");
        step(1'b1, 1'b0);
        check(2'd0, "R7 saturated count is late");

        // R8: press+tick while dark still clears the count
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        check(2'd1, "R8 on with tick");
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1);
        step(1'b1, 1'b0);
        check(2'd2, "R8 count cleared despite tick");

        // R1: reset mid-operation wins over a press
        @(negedge clk);
        rst   = 1'b1;
        press = 1'b1;
        @(posedge clk);
        #1;
        press = 1'b0;
        check(2'd0, "R1 reset from bright");
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b0);
        check(2'd0, "R6 idle after reset");

        // R9: encodings across all three levels
        step(1'b1, 1'b0);
        check(2'd1, "R9 normal encoding");
        step(1'b1, 1'b0);
        check(2'd2, "R9 bright encoding");
        step(1'b1, 1'b0);
        check(2'd0, "R9 dark encoding");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule